// File: doc/BRIEF.md
# Interlocked Handshake Bus Slave

This block is the target side of an 8-bit expansion bus with a 24-bit address. A transfer uses a four-phase handshake. The master drives address, direction and (for writes) data, then pulls the start strobe low. The addressed slave pulls the end acknowledge low once its access time has passed. The master then raises start, and the slave raises end after its recovery time. All bus strobes arrive asynchronously. The slave brings them onto its local clock through two-flop synchronizers, and it counts the access delay and the recovery hold in local clock cycles.

The slave answers two kinds of address. The first is its dedicated slot window, used when the slot-space strobe is low. In that case the top nibble must equal the I/O window value, the next nibble must equal the card's slot number, and the low 16 bits are the offset. The second is a fully decoded base window, used when the slot-space strobe is high and the base window is enabled. A hit in either window reaches a small register file, with the register index taken from the low address bits. Pad tri-stating is left outside the block: the acknowledge and the read data each come with their own enable output, and only an addressed slave raises them.

The controller is a four-state machine. The states are IDLE, WAIT (counting the access delay), HOLD (acknowledge low, counting the recovery time and waiting for start to rise) and SKIP (start seen low but the address is not ours, so wait for start to rise).

The transitions are:
- IDLE->WAIT: synchronized start is low and the decode hits.
- IDLE->SKIP: synchronized start is low and the decode misses.
- WAIT->HOLD: the delay count is exhausted.
- HOLD->IDLE: the recovery count is exhausted and synchronized start is high.
- SKIP->IDLE: synchronized start is high.

Top module: `ilk_slave`

## Requirements
- R1: After reset, the end output is high (negated), both end_oe_o and data_oe_o are low, and every register holds 0x00.
- R2: With slot_n_i low, the slave responds when addr_i[23:20] equals IO_NIB (default 0xF) and addr_i[19:16] equals slot_id_i. The register index is addr_i[RF_AW-1:0], and the other offset bits alias.
- R3: With slot_n_i high and base_en_i high, the slave responds when addr_i[23:RF_AW] equals base_i[23:RF_AW]. The register index is addr_i[RF_AW-1:0].
- R4: In every other case the slave does not respond: end_n_o stays high and neither enable rises. This includes a base-window match while slot_n_i is low, a wrong slot number, a wrong I/O nibble, a disabled base, and a base mismatch. A write that is not addressed leaves the register file unchanged.
- R5: For an addressed transfer, end_n_o falls exactly ACC_DLY+3 rising clock edges after start_n_i falls. The three extra edges are two synchronizer stages plus one capture edge.
- R6: After end_n_o falls, it stays low for max(REC_HOLD, h+3) edges, where h is the number of edges the master waits before raising start. end_n_o never rises while start is still low.
- R7: For a read (wr_n_i high), data_oe_o is high and data_o carries the indexed register only while end_n_o is low.
- R8: For a write (wr_n_i low), data_i is captured and written into the indexed register on the same edge that lowers end_n_o, and data_oe_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| start_n_i | input | 1 | Transfer start strobe, active low, asynchronous |
| wr_n_i | input | 1 | Direction, low = master writes |
| slot_n_i | input | 1 | Slot-space strobe, active low |
| addr_i | input | 24 | Bus address |
| data_i | input | 8 | Bus data from master |
| slot_id_i | input | 4 | This card's slot number |
| base_i | input | 24 | Base window address |
| base_en_i | input | 1 | Enables base-window decode |
| end_n_o | output | 1 | Acknowledge, active low |
| end_oe_o | output | 1 | Drive enable for acknowledge |
| data_o | output | 8 | Read data to master |
| data_oe_o | output | 1 | Drive enable for read data |

## Verification
Two events can land on the same clock edge.

The first pair is the register-file write and the lowering of the acknowledge. Each write goes into the file on exactly that edge, and it is judged by reading the register back in a later transfer through the other decode mode.

The second pair is the end of the recovery count and the synchronized rise of start. The bench varies how long the master holds start after seeing end, and one setting (h = REC_HOLD-3) makes both happen together. In every setting the measured acknowledge width must equal max(REC_HOLD, h+3).

// File: rtl/ilk_pkg.sv
package ilk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HOLD,
        ST_SKIP
    } ilk_state_e;
endpackage

// File: rtl/ilk_sync.sv
module ilk_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] st1_q;
    logic [W-1:0] st2_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st1_q[b] <= 1'b1;
                st2_q[b] <= 1'b1;
            end else begin
                st1_q[b] <= d_i[b];
                st2_q[b] <= st1_q[b];
            end
        end
    end

    assign q_o = st2_q;
endmodule

// File: rtl/ilk_decode.sv
module ilk_decode #(
    parameter int          AW     = 24,
    parameter int          RF_AW  = 4,
    parameter logic [3:0]  IO_NIB = 4'hF
) (
    input  logic [AW-1:0]    addr_i,
    input  logic             slot_n_i,
    input  logic [3:0]       slot_id_i,
    input  logic [AW-1:0]    base_i,
    input  logic             base_en_i,
    output logic             hit_o,
    output logic [RF_AW-1:0] idx_o
);
    logic slot_hit;
    logic base_hit;

    always_comb begin
        slot_hit = !slot_n_i && (addr_i[AW-1:AW-4] == IO_NIB)
                   && (addr_i[AW-5:AW-8] == slot_id_i);
        base_hit = slot_n_i && base_en_i
                   && (addr_i[AW-1:RF_AW] == base_i[AW-1:RF_AW]);
        hit_o    = slot_hit || base_hit;
        idx_o    = addr_i[RF_AW-1:0];
    end
endmodule

// File: rtl/ilk_regfile.sv
module ilk_regfile #(
    parameter int DW    = 8,
    parameter int RF_AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [RF_AW-1:0] widx_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [RF_AW-1:0] ridx_i,
    output logic [DW-1:0]    rdata_o
);
    localparam int DEPTH = 2 ** RF_AW;

    logic [DW-1:0] mem_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[e] <= '0;
            end else if (we_i && (widx_i == RF_AW'(e))) begin
                mem_q[e] <= wdata_i;
            end
        end
    end

    assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/ilk_slave.sv
module ilk_slave
    import ilk_pkg::*;
#(
    parameter int         AW       = 24,
    parameter int         DW       = 8,
    parameter int         RF_AW    = 4,
    parameter logic [3:0] IO_NIB   = 4'hF,
    parameter int         ACC_DLY  = 4,
    parameter int         REC_HOLD = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_n_i,
    input  logic          wr_n_i,
    input  logic          slot_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic [3:0]    slot_id_i,
    input  logic [AW-1:0] base_i,
    input  logic          base_en_i,
    output logic          end_n_o,
    output logic          end_oe_o,
    output logic [DW-1:0] data_o,
    output logic          data_oe_o
);
    localparam int MAXC = (ACC_DLY > REC_HOLD) ? ACC_DLY : REC_HOLD;
    localparam int CW   = $clog2(MAXC + 1);

    logic [2:0]       sync_q;
    logic             start_s;
    logic             wr_s;
    logic             slot_s;
    logic             hit;
    logic [RF_AW-1:0] idx;

    ilk_state_e       st_q, st_d;
    logic [CW-1:0]    cnt_q;
    logic [RF_AW-1:0] idx_q;
    logic             wr_q;
    logic [DW-1:0]    wdata_q;
    logic             rf_we;
    logic [DW-1:0]    rf_rdata;

    ilk_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({start_n_i, wr_n_i, slot_n_i}),
        .q_o   (sync_q)
    );
    assign start_s = sync_q[2];
    assign wr_s    = sync_q[1];
    assign slot_s  = sync_q[0];

    ilk_decode #(.AW(AW), .RF_AW(RF_AW), .IO_NIB(IO_NIB)) u_dec (
        .addr_i    (addr_i),
        .slot_n_i  (slot_s),
        .slot_id_i (slot_id_i),
        .base_i    (base_i),
        .base_en_i (base_en_i),
        .hit_o     (hit),
        .idx_o     (idx)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (!start_s) st_d = hit ? ST_WAIT : ST_SKIP;
            ST_WAIT: if (cnt_q == '0) st_d = ST_HOLD;
            ST_HOLD: if (cnt_q == '0 && start_s) st_d = ST_IDLE;
            ST_SKIP: if (start_s) st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && st_d == ST_WAIT) begin
                cnt_q   <= CW'(ACC_DLY - 1);
                idx_q   <= idx;
                wr_q    <= !wr_s;
                wdata_q <= data_i;
            end else if (st_q == ST_WAIT && st_d == ST_HOLD) begin
                cnt_q <= CW'(REC_HOLD - 1);
            end else if ((st_q == ST_WAIT || st_q == ST_HOLD) && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign rf_we = (st_q == ST_WAIT) && (cnt_q == '0) && wr_q;

    ilk_regfile #(.DW(DW), .RF_AW(RF_AW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (rf_we),
        .widx_i  (idx_q),
        .wdata_i (wdata_q),
        .ridx_i  (idx_q),
        .rdata_o (rf_rdata)
    );

    always_comb begin
        end_oe_o  = (st_q == ST_WAIT) || (st_q == ST_HOLD);
        end_n_o   = !(st_q == ST_HOLD);
        data_oe_o = (st_q == ST_HOLD) && !wr_q;
        data_o    = data_oe_o ? rf_rdata : '0;
    end
endmodule

// File: rtl/ilk_slave_chk.sv
module ilk_slave_chk #(
    parameter int ACC_DLY  = 4,
    parameter int REC_HOLD = 6
) (
    input logic clk,
    input logic rst_n,
    input logic start_n_i,
    input logic wr_n_i,
    input logic end_n_o,
    input logic end_oe_o,
    input logic data_oe_o
);
    logic [15:0] start_low_q;
    logic [15:0] end_low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_low_q <= '0;
            end_low_q   <= '0;
        end else begin
            start_low_q <= start_n_i ? '0 : ((start_low_q == 16'hFFFF) ? start_low_q : start_low_q + 1'b1);
            end_low_q   <= end_n_o   ? '0 : ((end_low_q   == 16'hFFFF) ? end_low_q   : end_low_q + 1'b1);
        end
    end

    assert_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(end_n_o) |-> (32'(start_low_q) >= ACC_DLY));

    assert_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_n_o) |-> (32'(end_low_q) >= REC_HOLD));

    assert_interlock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_n_o) |-> $past(start_n_i, 3));

    assert_end_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !end_oe_o |-> end_n_o);

    assert_read_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (!end_n_o && end_oe_o && wr_n_i));
endmodule

bind ilk_slave ilk_slave_chk #(.ACC_DLY(ACC_DLY), .REC_HOLD(REC_HOLD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_n_i (start_n_i),
    .wr_n_i    (wr_n_i),
    .end_n_o   (end_n_o),
    .end_oe_o  (end_oe_o),
    .data_oe_o (data_oe_o)
);

// File: tb/ilk_slave_bench.sv
module ilk_slave_bench;
    localparam int PERIOD = 10;
    localparam int ACC    = 4;
    localparam int REC    = 6;
    localparam int RF_AW  = 4;
    localparam logic [3:0]  MY_SLOT = 4'd3;
    localparam logic [23:0] BASE    = 24'h123450;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        slot_n = 1'b1;
    logic [23:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [23:0] base = BASE;
    logic        base_en = 1'b1;
    logic        end_n, end_oe, data_oe;
    logic [7:0]  rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit cur_hit = 1'b0;
    logic [7:0] exp_rf [16];

    always #(PERIOD/2) clk = ~clk;

    ilk_slave #(.ACC_DLY(ACC), .REC_HOLD(REC), .RF_AW(RF_AW)) u_ilk_slave (
        .clk (clk), .rst_n (rst_n), .start_n_i (start_n), .wr_n_i (wr_n),
        .slot_n_i (slot_n), .addr_i (addr), .data_i (wdata), .slot_id_i (MY_SLOT),
        .base_i (base), .base_en_i (base_en), .end_n_o (end_n), .end_oe_o (end_oe),
        .data_o (rdata), .data_oe_o (data_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: unaddressed driving (R4) and interlock violation (R6)
    logic prev_end_n = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if ((end_oe || data_oe) && !cur_hit)
                chk(1'b0, "R4 unaddressed drive", int'({end_oe, data_oe}), 0);
            if (!prev_end_n && end_n && !start_n)
                chk(1'b0, "R6 end rose while start low", 1, 0);
            prev_end_n <= end_n;
        end
    end

    task automatic xact(input logic [23:0] a, input logic sn, input logic wr,
                        input logic [7:0] d, input bit hit, input int hold);
        int edges;
        int dur;
        int expd;
        @(negedge clk);
        cur_hit = hit;
        addr = a; slot_n = sn; wr_n = !wr; wdata = d;
        start_n = 1'b0;
        if (hit) begin
            edges = 0;
            while (end_n && edges < 40) begin
                @(posedge clk); edges++;
                @(negedge clk);
            end
            chk(edges == ACC + 3, "R5 access latency", edges, ACC + 3);
            if (wr) begin
                chk(data_oe == 1'b0, "R8 no data drive on write", int'(data_oe), 0);
                exp_rf[a[RF_AW-1:0]] = d;
            end else begin
                chk(data_oe == 1'b1, "R7 read data enable", int'(data_oe), 1);
                chk(rdata == exp_rf[a[RF_AW-1:0]], "R7 read data value",
                    int'(rdata), int'(exp_rf[a[RF_AW-1:0]]));
            end
            dur = 0;
            for (int i = 0; i < hold; i++) begin
                @(posedge clk); dur++;
                @(negedge clk);
            end
            start_n = 1'b1;
            while (!end_n && dur < 60) begin
                @(posedge clk); dur++;
                @(negedge clk);
            end
            expd = (REC > hold + 3) ? REC : hold + 3;
            chk(dur == expd, "R6 end hold width", dur, expd);
        end else begin
            repeat (ACC + 8) @(negedge clk);
            chk(end_n == 1'b1, "R4 no acknowledge when unaddressed", int'(end_n), 1);
            start_n = 1'b1;
        end
        repeat (3) @(negedge clk);
        cur_hit = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) exp_rf[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(end_n == 1'b1 && end_oe == 1'b0 && data_oe == 1'b0, "R1 reset outputs",
            int'({end_n, end_oe, data_oe}), 4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 / R4: sweep every slot number; only own slot answers, reads reset value (R1)
        for (int s = 0; s < 16; s++)
            xact({4'hF, 4'(s), 16'h0005}, 1'b0, 1'b0, 8'h00, (4'(s) == MY_SLOT), 0);
        // R4: wrong I/O window nibble
        xact({4'hE, MY_SLOT, 16'h0001}, 1'b0, 1'b0, 8'h00, 1'b0, 0);

        // R3 / R8: base-mode writes to every register, hold varies (h=3 coincides with REC)
        for (int i = 0; i < 16; i++)
            xact(BASE | 24'(i), 1'b1, 1'b1, 8'(i * 17 + 5), 1'b1, i % 5);

        // R2 / R7: read back through slot window with aliased offset bits
        for (int i = 0; i < 16; i++)
            xact({4'hF, MY_SLOT, 12'hAB0, 4'(i)}, 1'b0, 1'b0, 8'h00, 1'b1, (i * 3) % 7);

        // R4: base match while slot strobe low must be ignored, even as a write
        xact(BASE | 24'h2, 1'b0, 1'b1, 8'hEE, 1'b0, 0);
        // R4: base mismatch, and base disabled
        xact(BASE + 24'h10, 1'b1, 1'b1, 8'hDD, 1'b0, 0);
        base_en = 1'b0;
        xact(BASE | 24'h3, 1'b1, 1'b1, 8'hCC, 1'b0, 0);
        base_en = 1'b1;
        // R4: writes were ignored
        xact(BASE | 24'h2, 1'b1, 1'b0, 8'h00, 1'b1, 0);
        xact(BASE | 24'h3, 1'b1, 1'b0, 8'h00, 1'b1, 0);

        // R8: slot-mode write then base-mode read, long master hold (R6)
        xact({4'hF, MY_SLOT, 16'h7777}, 1'b0, 1'b1, 8'hA5, 1'b1, 9);
        xact(BASE | 24'h7, 1'b1, 1'b0, 8'h00, 1'b1, 1);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule